// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns the two housekeeping duties of an asynchronous DRAM channel: bringing the memory up after power is applied, and keeping every row refreshed afterwards. Out of reset it holds both strobes inactive for a programmable quiet period. It then runs a fixed number of wake-up refresh cycles on its own, and only after that raises its ready flag to tell the access controller that normal traffic may start.

Once ready, an interval ticker produces one refresh obligation per programmed period. Obligations that cannot be served at once are kept in a small saturating debt counter. While debt is owed and the sequencer is idle, the block raises a request to the access controller. On each grant it takes the strobes and performs one refresh cycle. A build-time parameter selects the refresh style. In the first style the row is driven on the address pins from an internal row counter while only the row strobe pulses. In the second style the column strobe falls before the row strobe, the write enable stays high, and the device supplies the row itself.

Every timing window (quiet period, precharge, row-strobe width, column-before-row setup, refresh period) is a parameter expressed in clock cycles.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held, ram_ras_n, ram_cas_n and ram_we_n are 1, and ready, ref_req and ram_drive are 0.
- R2: After reset is released, neither strobe goes low during the first PAUSE_CYC clock cycles.
- R3: After the quiet period, exactly INIT_CNT refresh cycles (row strobe falls) occur without any grant. ready rises when the last one completes and stays high until reset.
- R4: With USE_CBR=0, ram_cas_n stays 1 for the whole refresh cycle, and ram_addr carries the row being refreshed while ram_ras_n is 0.
- R5: With USE_CBR=1, ram_cas_n is 0 for at least T_CSR cycles before ram_ras_n falls, and ram_we_n is 1 when ram_ras_n falls.
- R6: Before the first strobe of any refresh cycle goes low, both strobes have been high for at least T_RP consecutive cycles.
- R7: With USE_CBR=0, the row starts at 0, advances by one after each refresh (wake-up cycles included), and wraps from 2^ROW_W-1 to 0.
- R8: After ready, one obligation accrues every REFI_CYC cycles, whether or not a grant arrives. ref_req is 1 only while ready is 1, at least one obligation is owed, and no refresh is running.
- R9: Up to MAX_OWED owed refreshes are held. Further periods that pass while the count is full are dropped. A held grant serves the owed refreshes back to back, and ref_req then returns to 0.
- R10: ram_drive is 1 whenever the block holds a strobe low. It is 0 while the block is ready and idle.
- R11: During a refresh cycle, ram_ras_n stays low for exactly T_RAS consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Grant of the memory bus from the access controller |
| ref_req | output | 1 | Refresh wanted; bus requested |
| ready | output | 1 | Power-up sequence complete |
| ram_drive | output | 1 | Block is driving the DRAM strobes and address |
| ram_ras_n | output | 1 | Row strobe, active low |
| ram_cas_n | output | 1 | Column strobe, active low |
| ram_we_n | output | 1 | Write enable, active low (held high) |
| ram_addr | output | ROW_W | Row address for the row-strobe-only style |

## Verification
The bench builds two copies side by side, one per refresh style. Both use a 20-cycle quiet period, a 100-cycle refresh period, a debt limit of 3 and a 4-bit row. The short timers let the bench measure the full power-up sequence and the request latency in a few hundred cycles. The debt limit of 3 can be reached by withholding the grant across three periods, which exposes both the queueing and the dropping of excess ticks. The 4-bit row wraps after sixteen refreshes, so the roll-over from 15 to 0 falls inside a short run.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

    typedef enum logic [2:0] {
        PH_PAUSE = 3'd0,
        PH_IDLE  = 3'd1,
        PH_PRE   = 3'd2,
        PH_CSR   = 3'd3,
        PH_ACT   = 3'd4
    } phase_e;

    function automatic int max4(int a, int b, int c, int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/dram_ref_ticker.sv
module dram_ref_ticker #(
    parameter int PERIOD = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(PERIOD + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (en) begin
            if (cnt_q == '0) begin
                tick  = 1'b1;
                cnt_d = CW'(PERIOD - 1);
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= CW'(PERIOD - 1);
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dram_ref_debt.sv
module dram_ref_debt #(
    parameter int MAX_OWED = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic owed_nz
);
    localparam int OW = $clog2(MAX_OWED + 1);

    logic [OW-1:0] owed_d, owed_q;

    always_comb begin
        owed_d = owed_q;
        unique case ({inc, dec})
            2'b10: if (owed_q != OW'(MAX_OWED)) owed_d = owed_q + 1'b1;
            2'b01: if (owed_q != '0) owed_d = owed_q - 1'b1;
            default: owed_d = owed_q;
        endcase
    end

    assign owed_nz = (owed_q != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) owed_q <= '0;
        else        owed_q <= owed_d;
    end
endmodule

// File: rtl/dram_ref_seq.sv
module dram_ref_seq
    import dram_ref_pkg::*;
#(
    parameter bit USE_CBR   = 1'b0,
    parameter int ROW_W     = 10,
    parameter int PAUSE_CYC = 20000,
    parameter int INIT_CNT  = 8,
    parameter int T_RP      = 6,
    parameter int T_RAS     = 6,
    parameter int T_CSR     = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gnt,
    input  logic             owed_nz,
    output logic             start,
    output logic             idle,
    output logic             ready,
    output logic             drive,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [ROW_W-1:0] addr
);
    localparam int CNT_MAX = max4(PAUSE_CYC, T_RP, T_RAS, T_CSR);
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam int IW      = $clog2(INIT_CNT + 1);

    typedef struct packed {
        phase_e           phase;
        logic [CW-1:0]    cnt;
        logic [IW-1:0]    init_left;
        logic [ROW_W-1:0] row;
        logic             ready;
    } seq_t;

    seq_t st_d, st_q;

    // Phase after precharge depends on the refresh style.
    function automatic seq_t after_precharge(seq_t s);
        seq_t r;
        r = s;
        if (USE_CBR) begin
            r.phase = PH_CSR;
            r.cnt   = CW'(T_CSR - 1);
        end else begin
            r.phase = PH_ACT;
            r.cnt   = CW'(T_RAS - 1);
        end
        return r;
    endfunction

    always_comb begin
        st_d  = st_q;
        start = 1'b0;
        unique case (st_q.phase)
            PH_PAUSE: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_PRE;
                    st_d.cnt   = CW'(T_RP - 1);
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_IDLE: begin
                if (gnt && owed_nz) begin
                    start      = 1'b1;
                    st_d.phase = PH_PRE;
                    st_d.cnt   = CW'(T_RP - 1);
                end
            end
            PH_PRE: begin
                if (st_q.cnt == '0) st_d = after_precharge(st_q);
                else                st_d.cnt = st_q.cnt - 1'b1;
            end
            PH_CSR: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_ACT;
                    st_d.cnt   = CW'(T_RAS - 1);
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_ACT: begin
                if (st_q.cnt == '0) begin
                    if (!USE_CBR) st_d.row = st_q.row + 1'b1;
                    if (st_q.ready) begin
                        st_d.phase = PH_IDLE;
                    end else if (st_q.init_left == IW'(1)) begin
                        st_d.ready     = 1'b1;
                        st_d.init_left = '0;
                        st_d.phase     = PH_IDLE;
                    end else begin
                        st_d.init_left = st_q.init_left - 1'b1;
                        st_d.phase     = PH_PRE;
                        st_d.cnt       = CW'(T_RP - 1);
                    end
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            default: st_d.phase = PH_PAUSE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase     <= PH_PAUSE;
            st_q.cnt       <= CW'(PAUSE_CYC - 1);
            st_q.init_left <= IW'(INIT_CNT);
            st_q.row       <= '0;
            st_q.ready     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idle  = (st_q.phase == PH_IDLE);
    assign ready = st_q.ready;
    assign drive = (st_q.phase == PH_PRE) || (st_q.phase == PH_CSR) ||
                   (st_q.phase == PH_ACT);
    assign ras_n = (st_q.phase != PH_ACT);
    assign we_n  = 1'b1;

    generate
        if (USE_CBR) begin : g_cbr
            assign cas_n = !((st_q.phase == PH_CSR) || (st_q.phase == PH_ACT));
            assign addr  = '0;
        end else begin : g_ras_only
            assign cas_n = 1'b1;
            assign addr  = (st_q.phase == PH_ACT) ? st_q.row : '0;
        end
    endgenerate
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter bit USE_CBR   = 1'b0,
    parameter int ROW_W     = 10,
    parameter int PAUSE_CYC = 20000,
    parameter int INIT_CNT  = 8,
    parameter int REFI_CYC  = 1560,
    parameter int MAX_OWED  = 4,
    parameter int T_RP      = 6,
    parameter int T_RAS     = 6,
    parameter int T_CSR     = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_gnt,
    output logic             ref_req,
    output logic             ready,
    output logic             ram_drive,
    output logic             ram_ras_n,
    output logic             ram_cas_n,
    output logic             ram_we_n,
    output logic [ROW_W-1:0] ram_addr
);
    logic tick, start, idle, owed_nz;

    dram_ref_ticker #(.PERIOD(REFI_CYC)) u_ticker (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (ready),
        .tick (tick)
    );

    dram_ref_debt #(.MAX_OWED(MAX_OWED)) u_debt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (tick),
        .dec    (start),
        .owed_nz(owed_nz)
    );

    dram_ref_seq #(
        .USE_CBR  (USE_CBR),
        .ROW_W    (ROW_W),
        .PAUSE_CYC(PAUSE_CYC),
        .INIT_CNT (INIT_CNT),
        .T_RP     (T_RP),
        .T_RAS    (T_RAS),
        .T_CSR    (T_CSR)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .gnt    (ref_gnt),
        .owed_nz(owed_nz),
        .start  (start),
        .idle   (idle),
        .ready  (ready),
        .drive  (ram_drive),
        .ras_n  (ram_ras_n),
        .cas_n  (ram_cas_n),
        .we_n   (ram_we_n),
        .addr   (ram_addr)
    );

    assign ref_req = idle && owed_nz;
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
    parameter bit USE_CBR   = 1'b0,
    parameter int ROW_W     = 10,
    parameter int PAUSE_CYC = 20000,
    parameter int INIT_CNT  = 8,
    parameter int T_RP      = 6,
    parameter int T_CSR     = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_req,
    input logic             ready,
    input logic             ram_drive,
    input logic             ram_ras_n,
    input logic             ram_cas_n,
    input logic             ram_we_n,
    input logic [ROW_W-1:0] ram_addr
);
    localparam int PW = $clog2(PAUSE_CYC + 1);
    localparam int HW = $clog2(T_RP + 1);
    localparam int LW = $clog2(T_CSR + 1);
    localparam int FW = $clog2(INIT_CNT + 2);

    logic [PW-1:0]    since_rst;
    logic [HW-1:0]    hi_run;
    logic [LW-1:0]    csr_run;
    logic [FW-1:0]    pre_falls;
    logic             ras_prev, cas_prev, have_row;
    logic [ROW_W-1:0] last_row;
    logic             ras_fall, act_start;

    assign ras_fall  = ras_prev && !ram_ras_n;
    assign act_start = ras_prev && cas_prev && (!ram_ras_n || !ram_cas_n);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
            hi_run    <= '0;
            csr_run   <= '0;
            pre_falls <= '0;
            ras_prev  <= 1'b1;
            cas_prev  <= 1'b1;
            have_row  <= 1'b0;
            last_row  <= '0;
        end else begin
            if (since_rst != PW'(PAUSE_CYC)) since_rst <= since_rst + 1'b1;
            if (ram_ras_n && ram_cas_n) begin
                if (hi_run != HW'(T_RP)) hi_run <= hi_run + 1'b1;
            end else begin
                hi_run <= '0;
            end
            if (ram_ras_n && !ram_cas_n) begin
                if (csr_run != LW'(T_CSR)) csr_run <= csr_run + 1'b1;
            end else begin
                csr_run <= '0;
            end
            if (ras_fall && !ready && pre_falls != FW'(INIT_CNT + 1))
                pre_falls <= pre_falls + 1'b1;
            if (ras_fall) begin
                have_row <= 1'b1;
                last_row <= ram_addr;
            end
            ras_prev <= ram_ras_n;
            cas_prev <= ram_cas_n;
        end
    end

    assert_quiet_pause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != PW'(PAUSE_CYC)) |-> (ram_ras_n && ram_cas_n));

    assert_init_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (pre_falls == FW'(INIT_CNT)));

    assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    assert_precharge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        act_start |-> (hi_run == HW'(T_RP)));

    assert_req_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> (ready && !ram_drive));

    assert_drive_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_ras_n || !ram_cas_n) |-> ram_drive);

    generate
        if (USE_CBR) begin : g_cbr_chk
            assert_cbr_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
                ras_fall |-> (csr_run == LW'(T_CSR) && ram_we_n && !ram_cas_n));
        end else begin : g_ras_chk
            assert_cas_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
                !ram_ras_n |-> ram_cas_n);
            assert_row_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (ras_fall && have_row) |-> (ram_addr == ROW_W'(last_row + 1'b1)));
        end
    endgenerate
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
    .USE_CBR  (USE_CBR),
    .ROW_W    (ROW_W),
    .PAUSE_CYC(PAUSE_CYC),
    .INIT_CNT (INIT_CNT),
    .T_RP     (T_RP),
    .T_CSR    (T_CSR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_req  (ref_req),
    .ready    (ready),
    .ram_drive(ram_drive),
    .ram_ras_n(ram_ras_n),
    .ram_cas_n(ram_cas_n),
    .ram_we_n (ram_we_n),
    .ram_addr (ram_addr)
);

// File: tb/dram_refresh_sched_bench.sv
module dram_refresh_sched_bench;
    localparam int ROW_W     = 4;
    localparam int PAUSE_CYC = 20;
    localparam int INIT_CNT  = 8;
    localparam int REFI_CYC  = 100;
    localparam int MAX_OWED  = 3;
    localparam int T_RP      = 3;
    localparam int T_RAS     = 4;
    localparam int T_CSR     = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [1:0]       gnt = 2'b00;
    logic [1:0]       req, rdy, drv, rasn, casn, wen;
    logic [ROW_W-1:0] addr0, addr1;

    dram_refresh_sched #(
        .USE_CBR(1'b0), .ROW_W(ROW_W), .PAUSE_CYC(PAUSE_CYC), .INIT_CNT(INIT_CNT),
        .REFI_CYC(REFI_CYC), .MAX_OWED(MAX_OWED), .T_RP(T_RP), .T_RAS(T_RAS), .T_CSR(T_CSR)
    ) u_dram_refresh_sched (
        .clk(clk), .rst_n(rst_n), .ref_gnt(gnt[0]), .ref_req(req[0]), .ready(rdy[0]),
        .ram_drive(drv[0]), .ram_ras_n(rasn[0]), .ram_cas_n(casn[0]), .ram_we_n(wen[0]),
        .ram_addr(addr0)
    );

    dram_refresh_sched #(
        .USE_CBR(1'b1), .ROW_W(ROW_W), .PAUSE_CYC(PAUSE_CYC), .INIT_CNT(INIT_CNT),
        .REFI_CYC(REFI_CYC), .MAX_OWED(MAX_OWED), .T_RP(T_RP), .T_RAS(T_RAS), .T_CSR(T_CSR)
    ) u_dram_refresh_sched_cbr (
        .clk(clk), .rst_n(rst_n), .ref_gnt(gnt[1]), .ref_req(req[1]), .ready(rdy[1]),
        .ram_drive(drv[1]), .ram_ras_n(rasn[1]), .ram_cas_n(casn[1]), .ram_we_n(wen[1]),
        .ram_addr(addr1)
    );

    int n_checks = 0;
    int n_bad    = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    int exp_q0[$];
    int exp_q1[$];
    int model_row[2] = '{0, 0};
    int pushed[2]    = '{0, 0};
    int falls[2]     = '{0, 0};
    int init_falls[2] = '{0, 0};
    int hi_run[2]    = '{0, 0};
    int lo_run[2]    = '{0, 0};
    int act_run[2]   = '{0, 0};
    bit seen_act[2]  = '{0, 0};
    bit ras_prev[2]  = '{1, 1};
    bit cas_prev[2]  = '{1, 1};

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Driver side: push expected refreshes into the scoreboard.
    task automatic push_expected(input int k, input int n);
        for (int i = 0; i < n; i++) begin
            if (k == 0) exp_q0.push_back(model_row[0]);
            else        exp_q1.push_back(0);
            model_row[k] = (model_row[k] + 1) % (1 << ROW_W);
            pushed[k]++;
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_req(input int k);
        while (!req[k]) @(negedge clk);
    endtask

    // Monitor: pops expected items as the strobes show refresh cycles.
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            for (int k = 0; k < 2; k++) begin
                bit rf, cf, rr;
                int exp_row;
                rf = ras_prev[k] && !rasn[k];
                cf = cas_prev[k] && !casn[k];
                rr = !ras_prev[k] && rasn[k];
                if ((rf || cf) && !seen_act[k]) begin
                    seen_act[k] = 1'b1;
                    check(cyc > PAUSE_CYC, "R2 first strobe cycle", cyc, PAUSE_CYC + 1);
                end
                if ((k == 0 && rf) || (k == 1 && cf))
                    check(hi_run[k] >= T_RP, "R6 precharge cycles", hi_run[k], T_RP);
                if (rf) begin
                    falls[k]++;
                    if (!rdy[k]) init_falls[k]++;
                    check(drv[k], "R10 drive during refresh", drv[k], 1);
                    if (k == 0) begin
                        check(casn[0], "R4 cas high at ras fall", casn[0], 1);
                        if (exp_q0.size() == 0) begin
                            check(1'b0, "R9 unexpected refresh", falls[0], pushed[0]);
                        end else begin
                            exp_row = exp_q0.pop_front();
                            if (exp_row == 0 && falls[0] > 1)
                                check(addr0 == ROW_W'(exp_row), "R7 row wrap", addr0, exp_row);
                            else
                                check(addr0 == ROW_W'(exp_row), "R4 row address", addr0, exp_row);
                        end
                    end else begin
                        check(!casn[1] && lo_run[1] >= T_CSR, "R5 cas setup cycles", lo_run[1], T_CSR);
                        check(wen[1], "R5 we high at ras fall", wen[1], 1);
                        if (exp_q1.size() == 0) check(1'b0, "R9 unexpected refresh", falls[1], pushed[1]);
                        else void'(exp_q1.pop_front());
                    end
                end
                if (k == 0 && !rasn[0] && !casn[0])
                    check(1'b0, "R4 cas low in ras-only", casn[0], 1);
                if (rr) check(act_run[k] == T_RAS, "R11 ras low width", act_run[k], T_RAS);
                hi_run[k]  = (rasn[k] && casn[k]) ? hi_run[k] + 1 : 0;
                lo_run[k]  = (rasn[k] && !casn[k]) ? lo_run[k] + 1 : 0;
                act_run[k] = !rasn[k] ? act_run[k] + 1 : 0;
                ras_prev[k] = rasn[k];
                cas_prev[k] = casn[k];
            end
        end
    end

    task automatic run_inst(input int k);
        int t_rdy, t_req, f0;
        push_expected(k, INIT_CNT);
        while (!rdy[k]) @(negedge clk);
        t_rdy = cyc;
        check(init_falls[k] == INIT_CNT, "R3 wake-up cycles", init_falls[k], INIT_CNT);
        check(!req[k] && !drv[k], "R10 idle after ready", {req[k], drv[k]}, 0);
        // R8: first request one period after ready
        wait_req(k);
        t_req = cyc;
        check(t_req - t_rdy >= REFI_CYC - 1 && t_req - t_rdy <= REFI_CYC + 1,
              "R8 request latency", t_req - t_rdy, REFI_CYC);
        push_expected(k, 1);
        wait_cycles(REFI_CYC + REFI_CYC / 2);
        check(rdy[k], "R3 ready stays high", rdy[k], 1);
        push_expected(k, 1);
        f0 = falls[k];
        gnt[k] = 1'b1;
        wait_cycles(40);
        gnt[k] = 1'b0;
        check(falls[k] - f0 == 2, "R9 two owed served", falls[k] - f0, 2);
        check(!req[k], "R8 request drops when paid", req[k], 0);
        check(!drv[k], "R10 bus released", drv[k], 0);
        // R9 saturation: four periods owed, only MAX_OWED kept
        wait_req(k);
        push_expected(k, MAX_OWED);
        wait_cycles(3 * REFI_CYC + REFI_CYC / 2);
        f0 = falls[k];
        gnt[k] = 1'b1;
        wait_cycles(40);
        gnt[k] = 1'b0;
        check(falls[k] - f0 == MAX_OWED, "R9 saturated debt", falls[k] - f0, MAX_OWED);
        check(!req[k], "R9 request idle after debt", req[k], 0);
        // R7 wrap: single refreshes until the row rolls over
        for (int i = 0; i < 6; i++) begin
            wait_req(k);
            push_expected(k, 1);
            f0 = falls[k];
            gnt[k] = 1'b1;
            wait_cycles(20);
            gnt[k] = 1'b0;
            check(falls[k] - f0 == 1, "R8 one refresh per period", falls[k] - f0, 1);
        end
    endtask

    initial begin
        wait_cycles(3);
        // R1 reset state
        check(rasn == 2'b11 && casn == 2'b11 && wen == 2'b11, "R1 strobes high in reset",
              {rasn, casn, wen}, 6'h3f);
        check(rdy == 2'b00 && req == 2'b00 && drv == 2'b00, "R1 flags low in reset",
              {rdy, req, drv}, 0);
        rst_n = 1'b1;
        fork
            run_inst(0);
            run_inst(1);
        join
        wait_cycles(5);
        check(exp_q0.size() == 0, "R7 all rows seen", exp_q0.size(), 0);
        check(exp_q1.size() == 0, "R5 all refreshes seen", exp_q1.size(), 0);
        check(falls[0] == pushed[0], "R4 refresh total", falls[0], pushed[0]);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R8 watchdog expired", cyc, 0);
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end
endmodule